// File: doc/BRIEF.md
# Resistance-to-Frequency Measurement Counter

This block measures a sensor oscillator with a 16-bit counter. An external RC oscillator is charged through one of three resistors: a reference and two sensor resistors. Each resistor has its own drive output. Software runs a measurement on the reference resistor and then on a sensor resistor, and compares the two results elsewhere. The block does not compute the resistance ratio.

There are two ways to measure. In gated mode, rising edges of the oscillator are counted while a window is open. The window is opened and closed either by the enable bit alone or by the timer-2 gate input. In period mode, pulses of a reference clock are counted across exactly one oscillator period. The reference clock can be the frequency-generator output. This gives better resolution when the oscillator is slow.

The result is read one nibble at a time through a select input. A sticky overflow flag reports a count that ran past full scale. A single-cycle done pulse ends every measurement.

Top module: `rfc_meter`

## Requirements
- R1: After reset, the count is 0x0000, and `ovf_flag`, `done_irq`, `drv_rr`, `drv_rt` and `drv_rh` are all 0.
- R2: `rd_nib` returns count bits [4*k+3:4*k] for `rd_sel` = k, so select 0 gives the least significant nibble.
- R3: A control write (`ctrl_wr`=1) with `ctrl_din[3]`=1 (enable) clears the count and the overflow flag, and restarts the measurement.
- R4: Gated mode with software interval (`ctrl_din[5]`=0, `ctrl_din[4]`=0): every rising edge of `osc_in` adds one while enable is 1. A write that clears enable closes the window and gives exactly one `done_irq` pulse. It leaves the count unchanged.
- R5: Gated mode with timer interval (`ctrl_din[4]`=1): rising edges of `osc_in` count only while `tmr_gate` is 1. The falling edge of `tmr_gate` gives exactly one `done_irq` pulse of one cycle.
- R6: Period mode (`ctrl_din[5]`=1) is armed by the enable write. The first synchronized rising edge of `osc_in` opens the period and the next one closes it. A `ref_tick` in the cycle that opens the period is not counted. A `ref_tick` in the cycle that closes it is counted. With `ref_tick` held at 1, the count equals the oscillator period in clock cycles. Closing gives one `done_irq` pulse, and the count then stays frozen.
- R7: In gated timer mode, `osc_in` edges while `tmr_gate` is 0 leave the count unchanged.
- R8: An increment at 0xFFFF sets `ovf_flag` and the count holds at 0xFFFF. The flag stays set until an R3 clear.
- R9: The drive outputs follow the control bits with fixed priority. Bit 0 gives `drv_rr`, bit 1 gives `drv_rt` and bit 2 gives `drv_rh`, with RR above RT above RH. At most one drive output is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Sensor oscillator, asynchronous |
| ref_tick | input | 1 | Reference-clock pulse qualifier, clk domain |
| tmr_gate | input | 1 | Timer-2 interval gate, clk domain |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_din | input | 6 | Control value: [5] period mode, [4] timer gate, [3] enable, [2] RH, [1] RT, [0] RR |
| rd_sel | input | 2 | Nibble select for readout |
| rd_nib | output | 4 | Selected count nibble |
| ovf_flag | output | 1 | Sticky overflow flag |
| done_irq | output | 1 | One-cycle measurement-done pulse |
| drv_rr | output | 1 | Reference resistor drive |
| drv_rt | output | 1 | First sensor resistor drive |
| drv_rh | output | 1 | Second sensor resistor drive |

## Verification
In period mode, the closing oscillator edge and a reference tick can fall in the same cycle. One function stops the count and the other adds to it. The bench holds `ref_tick` at 1 through a period of 291 cycles and expects a count of exactly 291, which shows that the closing tick is counted and the opening tick is not. In the overflow run, the increment at 0xFFFF lands on the counter in the same cycle that sets the flag, and the bench expects the flag set with the count still at 0xFFFF.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam int CTL_W     = 6;
  localparam int CB_PERIOD = 5;
  localparam int CB_TSEL   = 4;
  localparam int CB_EN     = 3;
  localparam int CB_RH     = 2;
  localparam int CB_RT     = 1;
  localparam int CB_RR     = 0;

  typedef enum logic [1:0] {
    PM_IDLE = 2'd0,
    PM_ARM  = 2'd1,
    PM_RUN  = 2'd2
  } prd_state_t;
endpackage

// File: rtl/rfc_edge_sync.sv
module rfc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rfc_sat_counter.sv
module rfc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;
  logic         upd;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    upd   = clr | inc;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (inc) begin
      if (cnt_q == FULL) ovf_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/rfc_drive_sel.sv
module rfc_drive_sel (
  input  logic [2:0] req,
  output logic       rr,
  output logic       rt,
  output logic       rh
);
  always_comb begin
    rr = 1'b0;
    rt = 1'b0;
    rh = 1'b0;
    if (req[0])      rr = 1'b1;
    else if (req[1]) rt = 1'b1;
    else if (req[2]) rh = 1'b1;
  end
endmodule

// File: rtl/rfc_meter.sv
module rfc_meter #(
  parameter int CNT_W  = 16,
  parameter int NIB_W  = 4,
  parameter int SYNC_N = 2,
  localparam int NUM_NIB = CNT_W / NIB_W,
  localparam int SEL_W   = (NUM_NIB > 1) ? $clog2(NUM_NIB) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     osc_in,
  input  logic                     ref_tick,
  input  logic                     tmr_gate,
  input  logic                     ctrl_wr,
  input  logic [rfc_pkg::CTL_W-1:0] ctrl_din,
  input  logic [SEL_W-1:0]         rd_sel,
  output logic [NIB_W-1:0]         rd_nib,
  output logic                     ovf_flag,
  output logic                     done_irq,
  output logic                     drv_rr,
  output logic                     drv_rt,
  output logic                     drv_rh
);
  import rfc_pkg::*;

  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  prd_state_t       st_q, st_d;
  logic             gate_q, gate_eff, gate_fall;
  logic             done_q, done_d;
  logic             osc_rise, clr, inc, close_prd;
  logic [CNT_W-1:0] cnt;

  rfc_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(osc_in), .rise(osc_rise)
  );

  rfc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .cnt(cnt), .ovf(ovf_flag)
  );

  rfc_drive_sel u_drv (
    .req({ctrl_q[CB_RH], ctrl_q[CB_RT], ctrl_q[CB_RR]}),
    .rr(drv_rr), .rt(drv_rt), .rh(drv_rh)
  );

  // control register and gate / period sequencing
  always_comb begin
    ctrl_d    = ctrl_wr ? ctrl_din : ctrl_q;
    clr       = ctrl_wr & ctrl_din[CB_EN];
    gate_eff  = ctrl_q[CB_EN] & ~ctrl_q[CB_PERIOD] &
                (ctrl_q[CB_TSEL] ? tmr_gate : 1'b1);
    gate_fall = gate_q & ~gate_eff;
    close_prd = 1'b0;
    st_d      = st_q;
    if (clr) begin
      st_d = ctrl_din[CB_PERIOD] ? PM_ARM : PM_IDLE;
    end else if (ctrl_wr || !ctrl_q[CB_EN] || !ctrl_q[CB_PERIOD]) begin
      st_d = PM_IDLE;
    end else begin
      unique case (st_q)
        PM_ARM:  if (osc_rise) st_d = PM_RUN;
        PM_RUN:  if (osc_rise) begin
                   st_d      = PM_IDLE;
                   close_prd = 1'b1;
                 end
        default: st_d = PM_IDLE;
      endcase
    end
    inc    = (gate_eff & osc_rise) | ((st_q == PM_RUN) & ref_tick);
    done_d = gate_fall | close_prd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      st_q   <= PM_IDLE;
      gate_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_d;
      st_q   <= st_d;
      gate_q <= gate_eff;
      done_q <= done_d;
    end
  end

  assign done_irq = done_q;
  assign rd_nib   = cnt[rd_sel*NIB_W +: NIB_W];
endmodule

// File: rtl/rfc_meter_chk.sv
module rfc_meter_chk #(
  parameter int CNT_W = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ctrl_wr,
  input logic [rfc_pkg::CTL_W-1:0] ctrl_din,
  input logic [CNT_W-1:0]          count,
  input logic                      ovf_flag,
  input logic                      done_irq,
  input logic                      drv_rr,
  input logic                      drv_rt,
  input logic                      drv_rh
);
  assert_drive_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_rr, drv_rt, drv_rh}));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(ctrl_wr && ctrl_din[3])) |=> ovf_flag);

  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> (count == {CNT_W{1'b1}}));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_din[3]) |=> (count == '0 && !ovf_flag));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && ctrl_din[3]) |=>
      (count == $past(count) || count == $past(count) + 1'b1));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
endmodule

bind rfc_meter rfc_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_din(ctrl_din),
  .count(cnt), .ovf_flag(ovf_flag), .done_irq(done_irq),
  .drv_rr(drv_rr), .drv_rt(drv_rt), .drv_rh(drv_rh)
);

// File: tb/rfc_meter_bench.sv
module rfc_meter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_in = 1'b0;
  logic       ref_tick = 1'b0;
  logic       tmr_gate = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [5:0] ctrl_din = '0;
  logic [1:0] rd_sel = '0;
  logic [3:0] rd_nib;
  logic       ovf_flag, done_irq, drv_rr, drv_rt, drv_rh;

  int checks = 0;
  int fails  = 0;
  int done_seen = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfc_meter u_rfc_meter (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ref_tick(ref_tick),
    .tmr_gate(tmr_gate), .ctrl_wr(ctrl_wr), .ctrl_din(ctrl_din),
    .rd_sel(rd_sel), .rd_nib(rd_nib), .ovf_flag(ovf_flag),
    .done_irq(done_irq), .drv_rr(drv_rr), .drv_rt(drv_rt), .drv_rh(drv_rh)
  );

  always @(negedge clk) if (rst_n && done_irq) done_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_din = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic read_count(output logic [15:0] v);
    for (int k = 0; k < 4; k++) begin
      rd_sel = k[1:0];
      #1;
      v[k*4 +: 4] = rd_nib;
    end
  endtask

  task automatic osc_pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      osc_in = 1'b1; repeat (hi) @(negedge clk);
      osc_in = 1'b0; repeat (lo) @(negedge clk);
    end
  endtask

  task automatic t_reset_r1;
    logic [15:0] c;
    read_count(c);
    chk("R1 count", c, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 done", done_irq, 0);
    chk("R1 drives", {drv_rr, drv_rt, drv_rh}, 0);
  endtask

  task automatic t_soft_gate_r4;
    logic [15:0] c;
    int d0;
    wr(6'b001000);
    repeat (4) @(negedge clk);
    osc_pulses(5, 3, 3);
    repeat (6) @(negedge clk);
    read_count(c);
    chk("R4 count during window", c, 5);
    d0 = done_seen;
    wr(6'b000000);
    repeat (5) @(negedge clk);
    chk("R4 one done pulse", done_seen - d0, 1);
    read_count(c);
    chk("R4 count kept after close", c, 5);
  endtask

  task automatic t_timer_gate_r5_r7;
    logic [15:0] c;
    int d0;
    wr(6'b011000);
    repeat (3) @(negedge clk);
    osc_pulses(4, 3, 3);
    repeat (6) @(negedge clk);
    read_count(c);
    chk("R7 ignored while gate low", c, 0);
    tmr_gate = 1'b1;
    repeat (3) @(negedge clk);
    osc_pulses(7, 2, 4);
    repeat (6) @(negedge clk);
    d0 = done_seen;
    tmr_gate = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 done on gate fall", done_seen - d0, 1);
    read_count(c);
    chk("R5 count in timer window", c, 7);
    osc_pulses(3, 3, 3);
    repeat (6) @(negedge clk);
    read_count(c);
    chk("R7 ignored after gate fall", c, 7);
    wr(6'b000000);
  endtask

  task automatic t_period_r6_r2;
    logic [15:0] c;
    int d0;
    ref_tick = 1'b1;
    wr(6'b101000);
    repeat (5) @(negedge clk);
    d0 = done_seen;
    osc_in = 1'b1; repeat (10) @(negedge clk);
    osc_in = 1'b0; repeat (281) @(negedge clk);
    osc_in = 1'b1; repeat (10) @(negedge clk);
    osc_in = 1'b0; repeat (10) @(negedge clk);
    chk("R6 done pulse", done_seen - d0, 1);
    read_count(c);
    chk("R6 period count incl closing tick", c, 291);
    rd_sel = 2'd0; #1; chk("R2 nibble 0", rd_nib, 4'h3);
    rd_sel = 2'd1; #1; chk("R2 nibble 1", rd_nib, 4'h2);
    rd_sel = 2'd2; #1; chk("R2 nibble 2", rd_nib, 4'h1);
    rd_sel = 2'd3; #1; chk("R2 nibble 3", rd_nib, 4'h0);
    osc_pulses(2, 5, 5);
    repeat (20) @(negedge clk);
    read_count(c);
    chk("R6 count frozen after close", c, 291);
    ref_tick = 1'b0;
  endtask

  task automatic t_overflow_r8_r3;
    logic [15:0] c;
    ref_tick = 1'b1;
    wr(6'b101000);
    repeat (4) @(negedge clk);
    osc_pulses(1, 4, 4);
    repeat (65600) @(negedge clk);
    read_count(c);
    chk("R8 saturated count", c, 16'hFFFF);
    chk("R8 overflow set", ovf_flag, 1);
    osc_pulses(1, 4, 8);
    chk("R8 overflow sticky", ovf_flag, 1);
    ref_tick = 1'b0;
    wr(6'b001000);
    read_count(c);
    chk("R3 clear count", c, 0);
    chk("R3 clear overflow", ovf_flag, 0);
    wr(6'b000000);
  endtask

  task automatic t_drive_r9;
    wr(6'b000111);
    chk("R9 all requested -> RR", {drv_rr, drv_rt, drv_rh}, 3'b100);
    wr(6'b000110);
    chk("R9 RT over RH", {drv_rr, drv_rt, drv_rh}, 3'b010);
    wr(6'b000100);
    chk("R9 RH alone", {drv_rr, drv_rt, drv_rh}, 3'b001);
    wr(6'b000000);
    chk("R9 none", {drv_rr, drv_rt, drv_rh}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_soft_gate_r4();
    t_timer_gate_r5_r7();
    t_period_r6_r2();
    t_drive_r9();
    t_overflow_r8_r3();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule